// File: doc/BRIEF.md
# Clock Pulse Skipper

The block sits on a free-running clock-enable stream and removes a programmable share of its pulses, lowering the effective frequency of whatever that enable gates. The share comes from one of two sources picked by a select input: a skip percentage from 0 to 100, or a 2-bit coded level that maps onto a fixed percentage (none, light, medium and heavy). The result is a per-cycle pass/skip enable that is the input pulse with the chosen pulses removed.

Skipped pulses are spread evenly rather than in bursts. A phase accumulator holds a value in 0..SPAN-1. On every input pulse it adds the skip percentage, and the pulse is dropped whenever the sum reaches SPAN, which is then subtracted. Control is a two-state machine. `ST_PASS_ALL` forwards every pulse and holds the accumulator at zero. `ST_SKIP_ACTIVE` applies the skip pattern. The transition ENGAGE (ST_PASS_ALL to ST_SKIP_ACTIVE) is taken on an edge where the throttle enable is high. The transition RELEASE (ST_SKIP_ACTIVE to ST_PASS_ALL) is taken on an edge where it is low. Each state otherwise holds itself.

Top module: `pulse_skipper`

## Requirements
- R1: `pulse_out` is never high in a cycle where `pulse_in` is low.
- R2: Out of reset the block is in ST_PASS_ALL, and while in that state `pulse_out` equals `pulse_in`, whatever depth is programmed. Reset is asynchronous and active low.
- R3: With `use_level` = 0, the skip percentage is `depth_pct`, and a value above 100 counts as 100. Over any 100 consecutive input pulses in ST_SKIP_ACTIVE with a steady setting, exactly 100 minus the percentage pass.
- R4: With `use_level` = 1, `level_code` selects the percentage and `depth_pct` is ignored: code 0 skips 0 %, code 1 skips 50 %, code 2 skips 75 % and code 3 skips 85 %. While `use_level` = 0, `level_code` is ignored.
- R5: A percentage of 0 (or level code 0) passes every pulse. A percentage of 100 skips every pulse.
- R6: After an ENGAGE from a cleared accumulator at percentage d, the k-th input pulse (k from 1) is skipped exactly when floor(k*d/100) exceeds floor((k-1)*d/100). Skips are therefore evenly spread.
- R7: `throttle_en`, `use_level`, `depth_pct` and `level_code` are captured at a clock edge and act from the following cycle on. A change applied in a cycle therefore does not affect `pulse_out` in that same cycle.
- R8: A change of percentage does not reset the accumulator. The accumulator returns to zero only while the block is in ST_PASS_ALL.
- R9: Cycles without an input pulse leave the accumulator unchanged, so the pattern advances per input pulse, not per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| throttle_en | input | 1 | High to apply skipping (ENGAGE), low to pass all (RELEASE) |
| use_level | input | 1 | 1 selects `level_code`, 0 selects `depth_pct` |
| depth_pct | input | 7 | Skip percentage 0..100, values above 100 clamp to 100 |
| level_code | input | 2 | Coded level: 0 none, 1 = 50 %, 2 = 75 %, 3 = 85 % |
| pulse_in | input | 1 | Incoming clock-enable pulse stream |
| pulse_out | output | 1 | Pulse stream after skipping |

## Verification
`pulse_out` is a combinational function of `pulse_in` and registered state, so it is due in the same cycle as the input pulse. Settings and the enable act one edge after they are applied. The bench drives every input at the falling edge and samples `pulse_out` 1 ns later, before the next rising edge. The old-setting cycle and the new-setting cycle are each checked explicitly on either side of a change. Ratio checks count passes over exactly 100 input pulses taken after the setting has been captured. The spread check compares each pulse against the floor formula from a known cleared accumulator.

// File: rtl/skipper_pkg.sv
package skipper_pkg;
    localparam int LVL_W = 2;
    localparam int LVL_N = 1 << LVL_W;

    typedef enum logic [0:0] {
        ST_PASS_ALL    = 1'b0,
        ST_SKIP_ACTIVE = 1'b1
    } skip_state_e;
endpackage

// File: rtl/skip_ctrl_fsm.sv
module skip_ctrl_fsm
    import skipper_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic throttle_en,
    output logic active
);
    skip_state_e state_q;
    skip_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PASS_ALL;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: ENGAGE and RELEASE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PASS_ALL:    if (throttle_en)  state_d = ST_SKIP_ACTIVE;
            ST_SKIP_ACTIVE: if (!throttle_en) state_d = ST_PASS_ALL;
            default:        state_d = ST_PASS_ALL;
        endcase
    end

    // outputs
    always_comb begin
        active = 1'b0;
        unique case (state_q)
            ST_PASS_ALL:    active = 1'b0;
            ST_SKIP_ACTIVE: active = 1'b1;
            default:        active = 1'b0;
        endcase
    end
endmodule

// File: rtl/skip_depth_sel.sv
module skip_depth_sel
    import skipper_pkg::*;
#(
    parameter  int SPAN     = 100,
    parameter  int LVL1_PCT = 50,
    parameter  int LVL2_PCT = 75,
    parameter  int LVL3_PCT = 85,
    localparam int PCT_W    = $clog2(SPAN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             use_level,
    input  logic [PCT_W-1:0] depth_pct,
    input  logic [LVL_W-1:0] level_code,
    output logic [PCT_W-1:0] depth_q
);
    logic [PCT_W-1:0] lvl_tab [LVL_N];
    logic [PCT_W-1:0] pct_clamped;
    logic [PCT_W-1:0] depth_d;

    for (genvar g = 0; g < LVL_N; g++) begin : g_lvl
        localparam int RAW = (g == 0) ? 0 :
                             (g == 1) ? LVL1_PCT :
                             (g == 2) ? LVL2_PCT : LVL3_PCT;
        localparam int LIM = (RAW > SPAN) ? SPAN : RAW;
        assign lvl_tab[g] = PCT_W'(LIM);
    end

    always_comb begin
        pct_clamped = (depth_pct > PCT_W'(SPAN)) ? PCT_W'(SPAN) : depth_pct;
        depth_d     = use_level ? lvl_tab[level_code] : pct_clamped;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            depth_q <= '0;
        end else begin
            depth_q <= depth_d;
        end
    end
endmodule

// File: rtl/skip_phase_acc.sv
module skip_phase_acc #(
    parameter  int SPAN  = 100,
    localparam int PCT_W = $clog2(SPAN + 1),
    localparam int SUM_W = PCT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             pulse_in,
    input  logic [PCT_W-1:0] depth,
    output logic             skip,
    output logic [PCT_W-1:0] phase_q
);
    logic [SUM_W-1:0] sum;
    logic             wrap;

    always_comb begin
        sum  = SUM_W'(phase_q) + SUM_W'(depth);
        wrap = (sum >= SUM_W'(SPAN));
        skip = active & pulse_in & wrap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (!active) begin
            phase_q <= '0;
        end else if (pulse_in) begin
            phase_q <= wrap ? PCT_W'(sum - SUM_W'(SPAN)) : PCT_W'(sum);
        end
    end
endmodule

// File: rtl/pulse_skipper.sv
module pulse_skipper
    import skipper_pkg::*;
#(
    parameter  int SPAN     = 100,
    parameter  int LVL1_PCT = 50,
    parameter  int LVL2_PCT = 75,
    parameter  int LVL3_PCT = 85,
    localparam int PCT_W    = $clog2(SPAN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             throttle_en,
    input  logic             use_level,
    input  logic [PCT_W-1:0] depth_pct,
    input  logic [LVL_W-1:0] level_code,
    input  logic             pulse_in,
    output logic             pulse_out
);
    logic             active;
    logic             skip;
    logic [PCT_W-1:0] depth_q;
    logic [PCT_W-1:0] phase_q;

    skip_ctrl_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .throttle_en (throttle_en),
        .active      (active)
    );

    skip_depth_sel #(
        .SPAN     (SPAN),
        .LVL1_PCT (LVL1_PCT),
        .LVL2_PCT (LVL2_PCT),
        .LVL3_PCT (LVL3_PCT)
    ) u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .use_level  (use_level),
        .depth_pct  (depth_pct),
        .level_code (level_code),
        .depth_q    (depth_q)
    );

    skip_phase_acc #(
        .SPAN (SPAN)
    ) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .pulse_in (pulse_in),
        .depth    (depth_q),
        .skip     (skip),
        .phase_q  (phase_q)
    );

    assign pulse_out = pulse_in & ~skip;
endmodule

// File: rtl/pulse_skipper_chk.sv
module pulse_skipper_chk #(
    parameter  int SPAN  = 100,
    localparam int PCT_W = $clog2(SPAN + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             throttle_en,
    input logic             pulse_in,
    input logic             pulse_out,
    input logic             active,
    input logic [PCT_W-1:0] depth_q,
    input logic [PCT_W-1:0] phase_q
);
    // R1
    gate_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_out |-> pulse_in);

    // R2
    bypass_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(throttle_en) |-> (pulse_out == pulse_in));

    // R5
    full_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && depth_q == PCT_W'(SPAN)) |-> !pulse_out);

    // R5
    zero_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && depth_q == '0) |-> (pulse_out == pulse_in));

    // R6
    phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q < PCT_W'(SPAN));

    // R7
    engage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        throttle_en |=> active);

    // R7
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !throttle_en |=> !active);

    // R8
    clear_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (phase_q == '0));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && throttle_en && !pulse_in) |=> (phase_q == $past(phase_q)));
endmodule

bind pulse_skipper pulse_skipper_chk #(.SPAN(SPAN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .throttle_en (throttle_en),
    .pulse_in    (pulse_in),
    .pulse_out   (pulse_out),
    .active      (active),
    .depth_q     (depth_q),
    .phase_q     (phase_q)
);

// File: tb/pulse_skipper_test.sv
module pulse_skipper_test;
    localparam int NV = 12;
    // fields: [16] use_level, [15:14] level_code, [13:7] depth_pct, [6:0] expected passes per 100 pulses
    localparam logic [16:0] VECS [NV] = '{
        {1'b0, 2'd3, 7'd0,   7'd100},
        {1'b0, 2'd3, 7'd85,  7'd15},
        {1'b0, 2'd0, 7'd50,  7'd50},
        {1'b0, 2'd1, 7'd100, 7'd0},
        {1'b0, 2'd2, 7'd33,  7'd67},
        {1'b0, 2'd3, 7'd1,   7'd99},
        {1'b0, 2'd0, 7'd120, 7'd0},
        {1'b0, 2'd1, 7'd99,  7'd1},
        {1'b1, 2'd0, 7'd100, 7'd100},
        {1'b1, 2'd1, 7'd100, 7'd50},
        {1'b1, 2'd2, 7'd0,   7'd25},
        {1'b1, 2'd3, 7'd100, 7'd15}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       throttle_en = 1'b0;
    logic       use_level = 1'b0;
    logic [6:0] depth_pct = '0;
    logic [1:0] level_code = '0;
    logic       pulse_in = 1'b0;
    logic       pulse_out;
    int         checks = 0;
    int         errors = 0;

    always #2 clk = ~clk;

    pulse_skipper uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .throttle_en (throttle_en),
        .use_level   (use_level),
        .depth_pct   (depth_pct),
        .level_code  (level_code),
        .pulse_in    (pulse_in),
        .pulse_out   (pulse_out)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input logic p, output logic o);
        @(negedge clk);
        pulse_in = p;
        #1;
        o = pulse_out;
    endtask

    task automatic count_pass(input int n, output int passes);
        logic o;
        passes = 0;
        for (int i = 0; i < n; i++) begin
            cyc(1'b1, o);
            if (o) passes++;
        end
    endtask

    // drop to pass-all long enough for the accumulator to clear, then engage at depth d
    task automatic fresh_engage(input int d);
        logic o;
        @(negedge clk);
        throttle_en = 1'b0;
        pulse_in    = 1'b0;
        cyc(1'b0, o);
        cyc(1'b0, o);
        @(negedge clk);
        throttle_en = 1'b1;
        use_level   = 1'b0;
        depth_pct   = 7'(d);
        pulse_in    = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic o;
        int   p;
        int   mism;

        // R2: reset state is pass-through even with enable and full depth applied
        throttle_en = 1'b1;
        depth_pct   = 7'd100;
        cyc(1'b1, o);
        check("R2 reset pass", o, 1);
        cyc(1'b0, o);
        check("R1 no pulse in", o, 0);

        @(negedge clk);
        rst_n       = 1'b1;
        throttle_en = 1'b0;
        count_pass(20, p);
        check("R2 disabled passes all", p, 20);

        // R7: enable applied this cycle takes effect next cycle
        @(negedge clk);
        throttle_en = 1'b1;
        pulse_in    = 1'b1;
        #1;
        check("R7 engage latency old", pulse_out, 1);
        cyc(1'b1, o);
        check("R5 depth 100 skips", o, 0);

        // R3 / R4 / R5: table of settings and pass counts over 100 pulses
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            use_level  = VECS[v][16];
            level_code = VECS[v][15:14];
            depth_pct  = VECS[v][13:7];
            pulse_in   = 1'b0;
            count_pass(100, p);
            if (VECS[v][16]) check($sformatf("R4 level %0d", VECS[v][15:14]), p, int'(VECS[v][6:0]));
            else             check($sformatf("R3 pct %0d", VECS[v][13:7]), p, int'(VECS[v][6:0]));
        end

        // R6: even spread from a cleared accumulator
        for (int t = 0; t < 2; t++) begin
            automatic int d = (t == 0) ? 20 : 85;
            fresh_engage(d);
            mism = 0;
            for (int k = 1; k <= 100; k++) begin
                automatic int exp_pass = ((k * d) / 100 == ((k - 1) * d) / 100) ? 1 : 0;
                cyc(1'b1, o);
                if (int'(o) != exp_pass) mism++;
            end
            check($sformatf("R6 spread mismatches depth %0d", d), mism, 0);
        end

        // R8: accumulator kept across a depth change (50 then 60)
        fresh_engage(50);
        cyc(1'b1, o);
        check("R8 first pulse at 50", o, 1);
        @(negedge clk);
        depth_pct = 7'd60;
        pulse_in  = 1'b0;
        #1;
        check("R1 idle cycle", pulse_out, 0);
        cyc(1'b1, o);
        check("R8 phase kept on change", o, 0);

        // R7: depth applied in a pulse cycle uses the old value there
        @(negedge clk);
        depth_pct = 7'd90;
        pulse_in  = 1'b1;
        #1;
        check("R7 depth change old value", pulse_out, 1);
        cyc(1'b1, o);
        check("R7 depth change new value", o, 0);

        // R9: gaps between pulses do not advance the pattern
        @(negedge clk);
        depth_pct = 7'd50;
        pulse_in  = 1'b0;
        p = 0;
        mism = 0;
        for (int i = 0; i < 200; i++) begin
            cyc(i[0] == 1'b0, o);
            if (o && i[0] == 1'b0) p++;
            if (o && i[0] == 1'b1) mism++;
        end
        check("R9 passes over 100 sparse pulses", p, 50);
        check("R1 outputs on idle cycles", mism, 0);

        // R2 / R7: release takes effect next cycle
        @(negedge clk);
        depth_pct = 7'd100;
        pulse_in  = 1'b0;
        @(negedge clk);
        throttle_en = 1'b0;
        pulse_in    = 1'b1;
        #1;
        check("R7 release latency old", pulse_out, 0);
        cyc(1'b1, o);
        check("R2 pass after release", o, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule